// File: doc/BRIEF.md
# Single-Level Vectored Interrupt Sequencer

This block runs the hardware side of one level of interrupt for a small 8-bit processor with a 15-bit address space. It watches a level-sensitive request line. It accepts the request only at an instruction boundary and only while interrupts are not inhibited. On acceptance it sets the inhibit flag and raises acknowledge together with an operation request. It then takes an 8-bit vector from the data bus on the first cycle that the bus is marked valid.

The vector is not an index into a table. Bit 7 picks the addressing form. Bits 6 to 0 are a signed displacement from address zero, and the sum wraps inside the lowest 8K-byte page. In the relative form that sum is the entry point of the service routine. In the indirect form the sum is a pointer: the sequencer fetches two bytes from that address and the next one, and the low 15 bits of the pair become the entry point. The routine can therefore start anywhere in memory.

The sequencer then issues the subroutine call. It presents the target for one cycle and pushes the return address onto an 8-deep on-chip stack. The 3-bit pointer of that stack belongs to the processor status word and is brought out as a port. A return pops the stack. Executing the instructions themselves is the job of the surrounding core.

Top module: `irq_seq_top`

## Requirements
- R1: After reset, acknowledge, operation request, indirect fetch, call valid and push are all low, the inhibit flag is 0, the stack pointer is 0 and the top-of-stack output reads 0.
- R2: A request is accepted only on a clock edge where `instr_done_i` is high, `irq_req_i` is high and the inhibit flag is clear. `intack_o` is high from the cycle after that edge. No acceptance happens while `instr_done_i` stays low.
- R3: Acceptance sets the inhibit flag. While the flag is set, further requests are not accepted, even across instruction boundaries. A request that is held high stays pending and is taken at the first boundary after `inhibit_clr_i` has cleared the flag. If acceptance and a clear fall on the same edge, the flag ends up set.
- R4: `intack_o` and `opreq_o` are high together from acceptance until the edge at which `data_valid_i` is first high. The vector is latched on that edge, and `intack_o` is low in the following cycle.
- R5: If vector bit 7 is 0, `call_target_o` equals bits 6..0 sign-extended and reduced modulo 8192 (bits 14..13 are zero). `call_valid_o` is high for exactly the one cycle after the vector edge.
- R6: If vector bit 7 is 1, `ifetch_o` and `opreq_o` are high while the sequencer reads two bytes. The first read uses the address P, which is the R5 value of the vector. The second uses (P+1) mod 8192. Each byte is taken on an edge where `data_valid_i` is high. The first byte is the high byte. The target is {high[6:0], low}, and `call_valid_o` is high in the cycle after the second byte.
- R7: In the cycle where `call_valid_o` is high, `push_o` is high. After that edge the stack pointer equals the old pointer plus 1 mod 8, and `ret_top_o` equals the `ret_addr_i` value sampled at acceptance.
- R8: A pulse on `ret_pop_i` lowers the stack pointer by 1 mod 8, and `ret_top_o` then shows the entry at the new pointer. A ninth nested push overwrites the oldest entry, with no error indication.
- R9: A pop requested in the same cycle as a push is ignored. The pointer moves only by the push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req_i | input | 1 | Level interrupt request |
| instr_done_i | input | 1 | Current instruction completes at this edge |
| inhibit_clr_i | input | 1 | Software clears the inhibit flag |
| data_i | input | 8 | Data bus in (vector and pointer bytes) |
| data_valid_i | input | 1 | Data bus holds valid data at this edge |
| ret_addr_i | input | 15 | Return address to save on acceptance |
| ret_pop_i | input | 1 | Return from subroutine: pop the stack |
| intack_o | output | 1 | Interrupt acknowledge |
| opreq_o | output | 1 | Operation request for a bus cycle |
| ifetch_o | output | 1 | Indirect pointer byte fetch in progress |
| ifetch_addr_o | output | 15 | Address of the pointer byte being fetched |
| call_valid_o | output | 1 | Call target valid (one cycle) |
| call_target_o | output | 15 | Entry address of the service routine |
| push_o | output | 1 | Return address push strobe |
| inhibit_o | output | 1 | Interrupt inhibit flag |
| sp_o | output | 3 | Stack pointer field of the status word |
| ret_top_o | output | 15 | Stack entry at the current pointer |

## Verification
The bench builds the block with its default parameters: a 15-bit address, an 8-entry stack and an 8K-byte page. At these values a short run of nested calls wraps the 3-bit pointer, which makes the silent overwrite of the oldest return address visible through pops. The negative displacement -1 (vector 0xFF) gives the pointer 0x1FFF, so the second pointer fetch must wrap to 0x0000 inside the page. The random vectors cover both addressing forms and both signs, with varied delays before the data bus turns valid.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE   = 3'd0,
    SQ_ACK    = 3'd1,
    SQ_PTR_HI = 3'd2,
    SQ_PTR_LO = 3'd3,
    SQ_CALL   = 3'd4
  } seq_state_e;

endpackage

// File: rtl/irq_vec_calc.sv
module irq_vec_calc #(
  parameter int AW = 15,
  parameter int VW = 8,
  parameter int PW = 13
) (
  input  logic [VW-1:0] vec_i,
  input  logic [AW-1:0] ptr_i,
  output logic          ind_o,
  output logic [AW-1:0] rel_o,
  output logic [AW-1:0] ptr_next_o
);

  localparam int DW = VW - 1;

  // Signed displacement added to location zero, kept inside the low page.
  function automatic logic [AW-1:0] rel_from_zero(input logic [VW-1:0] v);
    logic [PW-1:0] s;
    s = {{(PW-DW){v[DW-1]}}, v[DW-1:0]};
    return {{(AW-PW){1'b0}}, s};
  endfunction

  // Next byte address, wrapping inside the page holding the pointer.
  function automatic logic [AW-1:0] page_next(input logic [AW-1:0] p);
    logic [PW-1:0] lo;
    lo = p[PW-1:0] + 1'b1;
    return {p[AW-1:PW], lo};
  endfunction

  always_comb begin
    ind_o      = vec_i[VW-1];
    rel_o      = rel_from_zero(vec_i);
    ptr_next_o = page_next(ptr_i);
  end

endmodule

// File: rtl/irq_ret_stack.sv
module irq_ret_stack #(
  parameter int AW    = 15,
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push_i,
  input  logic                     pop_i,
  input  logic [AW-1:0]            push_data_i,
  output logic [$clog2(DEPTH)-1:0] sp_o,
  output logic [AW-1:0]            top_o
);

  localparam int SPW = $clog2(DEPTH);

  logic [SPW-1:0] sp_q;
  logic [SPW-1:0] sp_up;
  logic [SPW-1:0] sp_dn;
  logic [AW-1:0]  ent_q [DEPTH];

  assign sp_up = sp_q + 1'b1;
  assign sp_dn = sp_q - 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q <= '0;
    end else if (push_i) begin
      sp_q <= sp_up;
    end else if (pop_i) begin
      sp_q <= sp_dn;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_q[g] <= '0;
      end else if (push_i && (sp_up == SPW'(g))) begin
        ent_q[g] <= push_data_i;
      end
    end
  end

  assign sp_o  = sp_q;
  assign top_o = ent_q[sp_q];

  p_sp_push_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |=> sp_q == SPW'($past(sp_q) + 1));

  p_sp_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i) |=> sp_q == SPW'($past(sp_q) - 1));

  p_top_after_push_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |=> top_o == $past(push_data_i));

endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irq_seq_pkg::*;
#(
  parameter int AW = 15,
  parameter int VW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq_req_i,
  input  logic          instr_done_i,
  input  logic          inhibit_clr_i,
  input  logic [VW-1:0] data_i,
  input  logic          data_valid_i,
  input  logic [AW-1:0] ret_addr_i,
  input  logic          ind_i,
  input  logic [AW-1:0] rel_i,
  input  logic [AW-1:0] ptr_next_i,
  output logic [AW-1:0] ptr_o,
  output logic          intack_o,
  output logic          opreq_o,
  output logic          ifetch_o,
  output logic          call_valid_o,
  output logic [AW-1:0] call_target_o,
  output logic          push_o,
  output logic [AW-1:0] push_data_o,
  output logic          inhibit_o
);

  seq_state_e    st_q;
  logic          inh_q;
  logic          accept;
  logic          vec_take;
  logic [AW-1:0] ret_q;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] tgt_q;
  logic [VW-1:0] hi_q;
  logic [2*VW-1:0] pair;

  assign accept   = (st_q == SQ_IDLE) && irq_req_i && instr_done_i && !inh_q;
  assign vec_take = (st_q == SQ_ACK) && data_valid_i;
  assign pair     = {hi_q, data_i};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      ret_q  <= '0;
      addr_q <= '0;
      tgt_q  <= '0;
      hi_q   <= '0;
    end else begin
      case (st_q)
        SQ_IDLE: begin
          if (accept) begin
            ret_q <= ret_addr_i;
            st_q  <= SQ_ACK;
          end
        end
        SQ_ACK: begin
          if (data_valid_i) begin
            if (ind_i) begin
              addr_q <= rel_i;
              st_q   <= SQ_PTR_HI;
            end else begin
              tgt_q <= rel_i;
              st_q  <= SQ_CALL;
            end
          end
        end
        SQ_PTR_HI: begin
          if (data_valid_i) begin
            hi_q   <= data_i;
            addr_q <= ptr_next_i;
            st_q   <= SQ_PTR_LO;
          end
        end
        SQ_PTR_LO: begin
          if (data_valid_i) begin
            tgt_q <= pair[AW-1:0];
            st_q  <= SQ_CALL;
          end
        end
        SQ_CALL: st_q <= SQ_IDLE;
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inh_q <= 1'b0;
    end else if (accept) begin
      inh_q <= 1'b1;
    end else if (inhibit_clr_i) begin
      inh_q <= 1'b0;
    end
  end

  always_comb begin
    intack_o      = (st_q == SQ_ACK);
    ifetch_o      = (st_q == SQ_PTR_HI) || (st_q == SQ_PTR_LO);
    opreq_o       = intack_o || ifetch_o;
    call_valid_o  = (st_q == SQ_CALL);
    push_o        = call_valid_o;
    call_target_o = tgt_q;
    push_data_o   = ret_q;
    ptr_o         = addr_q;
    inhibit_o     = inh_q;
  end

  p_ack_needs_boundary_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intack_o) |-> $past(instr_done_i) && $past(irq_req_i));

  p_inhibit_on_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intack_o) |-> inhibit_o);

  p_no_ack_while_inh_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit_o && !intack_o && !ifetch_o && !call_valid_o) |=> !intack_o);

  p_ack_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (intack_o && !data_valid_i) |=> intack_o && opreq_o);

  p_ack_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vec_take |=> !intack_o);

  p_phase_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({intack_o, ifetch_o, call_valid_o}));

  p_direct_page_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_take && !data_i[VW-1]) |=> call_valid_o && (call_target_o[AW-1:AW-2] == 2'b00));

  p_call_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    call_valid_o |=> !call_valid_o);

  p_indirect_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_take && data_i[VW-1]) |=> ifetch_o && opreq_o);

endmodule

// File: rtl/irq_seq_top.sv
module irq_seq_top #(
  parameter int AW    = 15,
  parameter int VW    = 8,
  parameter int PW    = 13,
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     irq_req_i,
  input  logic                     instr_done_i,
  input  logic                     inhibit_clr_i,
  input  logic [VW-1:0]            data_i,
  input  logic                     data_valid_i,
  input  logic [AW-1:0]            ret_addr_i,
  input  logic                     ret_pop_i,
  output logic                     intack_o,
  output logic                     opreq_o,
  output logic                     ifetch_o,
  output logic [AW-1:0]            ifetch_addr_o,
  output logic                     call_valid_o,
  output logic [AW-1:0]            call_target_o,
  output logic                     push_o,
  output logic                     inhibit_o,
  output logic [$clog2(DEPTH)-1:0] sp_o,
  output logic [AW-1:0]            ret_top_o
);

  logic          ind_w;
  logic [AW-1:0] rel_w;
  logic [AW-1:0] ptr_next_w;
  logic [AW-1:0] ptr_w;
  logic [AW-1:0] push_data_w;
  logic          pop_ok_w;

  irq_vec_calc #(.AW(AW), .VW(VW), .PW(PW)) u_calc (
    .vec_i      (data_i),
    .ptr_i      (ptr_w),
    .ind_o      (ind_w),
    .rel_o      (rel_w),
    .ptr_next_o (ptr_next_w)
  );

  irq_seq_fsm #(.AW(AW), .VW(VW)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .irq_req_i     (irq_req_i),
    .instr_done_i  (instr_done_i),
    .inhibit_clr_i (inhibit_clr_i),
    .data_i        (data_i),
    .data_valid_i  (data_valid_i),
    .ret_addr_i    (ret_addr_i),
    .ind_i         (ind_w),
    .rel_i         (rel_w),
    .ptr_next_i    (ptr_next_w),
    .ptr_o         (ptr_w),
    .intack_o      (intack_o),
    .opreq_o       (opreq_o),
    .ifetch_o      (ifetch_o),
    .call_valid_o  (call_valid_o),
    .call_target_o (call_target_o),
    .push_o        (push_o),
    .push_data_o   (push_data_w),
    .inhibit_o     (inhibit_o)
  );

  // A return in the cycle of the interrupt push loses to the push.
  assign pop_ok_w = ret_pop_i && !push_o;

  irq_ret_stack #(.AW(AW), .DEPTH(DEPTH)) u_stack (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (push_o),
    .pop_i       (pop_ok_w),
    .push_data_i (push_data_w),
    .sp_o        (sp_o),
    .top_o       (ret_top_o)
  );

  assign ifetch_addr_o = ptr_w;

  p_push_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (push_o && ret_pop_i) |=> ret_top_o == $past(push_data_w));

endmodule

// File: tb/irq_seq_top_tb_top.sv
module irq_seq_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq = 1'b0, done = 1'b0, iclr = 1'b0, dv = 1'b0, pop = 1'b0;
  logic [7:0]  data = 8'h00;
  logic [14:0] ret = 15'h0;
  logic        intack, opreq, ifetch, cvalid, push, inh;
  logic [14:0] faddr, target, top;
  logic [2:0]  sp;

  int errors = 0;
  int checks = 0;
  int msp = 0;
  logic [14:0] mstk [8];

  always #4 clk = ~clk;

  irq_seq_top dut_i (
    .clk(clk), .rst_n(rst_n), .irq_req_i(irq), .instr_done_i(done),
    .inhibit_clr_i(iclr), .data_i(data), .data_valid_i(dv), .ret_addr_i(ret),
    .ret_pop_i(pop), .intack_o(intack), .opreq_o(opreq), .ifetch_o(ifetch),
    .ifetch_addr_o(faddr), .call_valid_o(cvalid), .call_target_o(target),
    .push_o(push), .inhibit_o(inh), .sp_o(sp), .ret_top_o(top)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [14:0] exp_rel(input logic [7:0] v);
    int d;
    d = v[6] ? int'(v[6:0]) - 128 : int'(v[6:0]);
    return 15'((d + 8192) % 8192);
  endfunction

  function automatic logic [14:0] exp_next(input logic [14:0] p);
    return 15'((int'(p) + 1) % 8192);
  endfunction

  task automatic service(input logic [14:0] r, input logic [7:0] v, input logic [7:0] hi,
                         input logic [7:0] lo, input int gap, input bit pop_in_call,
                         input bit clear_after);
    logic [14:0] tgt;
    logic [14:0] p;
    @(negedge clk); irq = 1'b1; done = 1'b1; ret = r;
    check("R2 no ack before edge", intack, 0);
    @(negedge clk); done = 1'b0; ret = 15'($urandom);
    check("R2 ack after boundary", intack, 1);
    check("R4 opreq with ack", opreq, 1);
    check("R3 inhibit set", inh, 1);
    for (int i = 0; i < gap; i++) begin
      @(negedge clk);
      check("R4 ack held", intack, 1);
    end
    data = v; dv = 1'b1;
    @(negedge clk); dv = 1'b0; data = 8'($urandom);
    check("R4 ack dropped", intack, 0);
    p = exp_rel(v);
    if (v[7]) begin
      check("R6 fetch hi", ifetch, 1);
      check("R6 opreq hi", opreq, 1);
      check("R6 addr hi", faddr, p);
      data = hi; dv = 1'b1;
      @(negedge clk); dv = 1'b0;
      check("R6 fetch lo", ifetch, 1);
      check("R6 addr lo", faddr, exp_next(p));
      data = lo; dv = 1'b1;
      @(negedge clk); dv = 1'b0;
      tgt = {hi[6:0], lo};
      check("R6 call valid", cvalid, 1);
      check("R6 target", target, tgt);
    end else begin
      tgt = p;
      check("R5 call valid", cvalid, 1);
      check("R5 target", target, tgt);
    end
    check("R7 push strobe", push, 1);
    pop = pop_in_call;
    @(negedge clk); pop = 1'b0; irq = 1'b0;
    msp = (msp + 1) % 8;
    mstk[msp] = r;
    check(pop_in_call ? "R9 sp push over pop" : "R7 sp after push", sp, msp);
    check("R7 top after push", top, r);
    check("R5 call single cycle", cvalid, 0);
    if (clear_after) begin
      iclr = 1'b1;
      @(negedge clk); iclr = 1'b0;
      check("R3 inhibit cleared", inh, 0);
    end
  endtask

  task automatic do_pop(input string tag);
    @(negedge clk); pop = 1'b1;
    @(negedge clk); pop = 1'b0;
    msp = (msp + 7) % 8;
    check({tag, " sp"}, sp, msp);
    check({tag, " top"}, top, mstk[msp]);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd20250117));
    for (int i = 0; i < 8; i++) mstk[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 intack", intack, 0);
    check("R1 opreq", opreq, 0);
    check("R1 ifetch", ifetch, 0);
    check("R1 call valid", cvalid, 0);
    check("R1 push", push, 0);
    check("R1 inhibit", inh, 0);
    check("R1 sp", sp, 0);
    check("R1 top", top, 0);

    // Request without a boundary is not taken
    irq = 1'b1;
    repeat (3) @(negedge clk);
    check("R2 waits for boundary", intack, 0);
    irq = 1'b0;

    // Directed vectors: positive, negative, page wrap of pointer
    service(15'h1234, 8'h3F, 8'h00, 8'h00, 0, 1'b0, 1'b1);
    service(15'h0ABC, 8'h40, 8'h00, 8'h00, 2, 1'b0, 1'b1);
    service(15'h7FFF, 8'hFF, 8'hC5, 8'h9A, 1, 1'b0, 1'b1);
    service(15'h0001, 8'h80, 8'h12, 8'h34, 0, 1'b0, 1'b1);

    // Pending while inhibited
    service(15'h2222, 8'h05, 8'h00, 8'h00, 0, 1'b0, 1'b0);
    @(negedge clk); irq = 1'b1; done = 1'b1;
    @(negedge clk); done = 1'b0;
    check("R3 held off while inhibited", intack, 0);
    iclr = 1'b1;
    @(negedge clk); iclr = 1'b0;
    check("R3 clear drops inhibit", inh, 0);
    check("R2 still waits boundary", intack, 0);
    service(15'h3333, 8'h11, 8'h00, 8'h00, 0, 1'b0, 1'b1);

    // Clear and acceptance on the same edge: flag stays set
    @(negedge clk); irq = 1'b1; done = 1'b1; iclr = 1'b1; ret = 15'h0444;
    @(negedge clk); done = 1'b0; iclr = 1'b0;
    check("R3 accept beats clear", inh, 1);
    check("R3 accepted with clear", intack, 1);
    data = 8'h01; dv = 1'b1;
    @(negedge clk); dv = 1'b0; irq = 1'b0;
    check("R5 target 1", target, 15'h0001);
    @(negedge clk);
    msp = (msp + 1) % 8; mstk[msp] = 15'h0444;
    check("R7 sp", sp, msp);
    iclr = 1'b1;
    @(negedge clk); iclr = 1'b0;

    // Pop during push is ignored
    service(15'h5A5A, 8'h22, 8'h00, 8'h00, 0, 1'b1, 1'b1);
    do_pop("R8 pop");

    // Random mix
    for (int n = 0; n < 40; n++) begin
      v = 8'($urandom);
      service(15'($urandom), v, 8'($urandom), 8'($urandom), int'($urandom % 4), 1'b0, 1'b1);
      if (($urandom % 3) == 0) do_pop("R8 random pop");
    end

    // Nine nested pushes then unwind: oldest overwritten
    for (int k = 0; k < 9; k++)
      service(15'(16'h0100 + k), 8'h07, 8'h00, 8'h00, 0, 1'b0, 1'b1);
    for (int k = 0; k < 8; k++) do_pop("R8 unwind");
    check("R8 overwrite of oldest", top, 15'h0108);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule